// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block makes the timing pulses for a UART transmitter and receiver from a single system clock. Every clock it produces either a one-cycle oversample tick or nothing. The oversample tick runs at sixteen times the serial bit rate. A second output, the bit tick, marks every sixteenth oversample tick and paces the transmitter's bit shifting.

A single 16-bit rate value drives two schemes, and a mode input chooses between them at run time. The integer divider suits low bit rates. The value is the clock frequency divided by sixteen times the bit rate. A down-counter reloads from it and gives one tick per reload. The fractional accumulator suits rates above 19200 bit/s. The value is the bit rate times sixteen times 65536, divided by the clock frequency. It is added to a 16-bit phase register every clock, and each carry out of the top bit gives a tick.

A run enable gates the block. While run is low, all state is held at zero and no pulses come out. Starting the block from that cleared state makes the first tick fall in a known cycle.

Top module: `baud_tick_gen`

## Requirements
- R1: In divider mode (`frac_mode`=0) with `baud_val`=N, N>=2, held constant, `os_tick` is high in the first cycle after the first clock edge with `run` high. After that it is high once every N cycles and low in between.
- R2: In divider mode, a `baud_val` of 0 or 1 makes `os_tick` high in every cycle while `run` is high.
- R3: In accumulator mode (`frac_mode`=1), the phase register P starts at 0. At each edge with `run` high, P+`baud_val` is formed. `os_tick` is high in the following cycle exactly when that sum is 65536 or more, and P takes the sum modulo 65536.
- R4: The input `frac_mode` selects the scheme: 0 selects the divider and 1 selects the accumulator. The same `baud_val` gives the tick pattern of the selected scheme only.
- R5: While `run` is low, `os_tick` and `bit_tick` are 0 from the next cycle on. The counter, the phase register and the prescaler are cleared, so a restart repeats the timing of R1 or R3 from its start.
- R6: In divider mode, a change of `baud_val` while running does not shorten or stretch the interval in progress. The new value sets the interval that starts at the next tick.
- R7: `bit_tick` is high together with every sixteenth `os_tick` counted since `run` rose, that is, with the 16th, 32nd and so on, and low otherwise.
- R8: In accumulator mode, a change of `baud_val` is used by the very next addition.
- R9: During and right after reset, with `run` low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_val | input | 16 | Rate value: reload count or phase increment |
| frac_mode | input | 1 | 0 = integer divider, 1 = fractional accumulator |
| run | input | 1 | Enables tick generation; low clears all state |
| os_tick | output | 1 | One-cycle pulse at 16x the bit rate |
| bit_tick | output | 1 | One-cycle pulse on every 16th oversample tick |

## Verification
The divider is run with a mid-range count, with the degenerate counts 0 and 1, and with a count rewritten partway through an interval. These runs separate the reload-time sampling of R6 from immediate use, and an off-by-one reload from a correct one. The accumulator is given a small increment, an increment whose ticks are unevenly spaced, one above half scale that gives back-to-back ticks, and a rewrite while running. Together these expose a wrong carry position or a delayed update. Stop and restart segments, long enough to reach several sixteen-tick groups, show whether the clear on restart and the prescaler phase are right.

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic {
    MODE_DIV = 1'b0,
    MODE_ACC = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/btg_divider.sv
module btg_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] load_val,
  output logic         fire
);
  logic [W-1:0] cnt;

  // A count of 0 (fresh start) or 1 (end of interval) means reload now.
  function automatic logic at_reload(input logic [W-1:0] c);
    return (c <= W'(1));
  endfunction

  assign fire = run & at_reload(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (fire)    cnt <= load_val;
    else              cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/btg_accum.sv
module btg_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] incr,
  output logic         carry
);
  logic [W-1:0] phase;
  logic [W:0]   sum;

  function automatic logic [W:0] phase_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum   = phase_add(phase, incr);
  assign carry = run & sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= sum[W-1:0];
  end
endmodule

// File: rtl/btg_prescale.sv
module btg_prescale #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_in,
  output logic tick_out
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pre;

  function automatic logic [PW-1:0] pre_next(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      tick_out <= 1'b0;
    end else if (!run) begin
      pre      <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= tick_in & (pre == LAST);
      if (tick_in) pre <= pre_next(pre);
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import btg_pkg::*;
#(
  parameter int BAUD_W = 16,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAUD_W-1:0] baud_val,
  input  logic              frac_mode,
  input  logic              run,
  output logic              os_tick,
  output logic              bit_tick
);
  gen_mode_e mode;
  logic      div_fire;
  logic      acc_carry;
  logic      tick_next;

  assign mode = gen_mode_e'(frac_mode);

  btg_divider #(.W(BAUD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .load_val(baud_val), .fire(div_fire)
  );

  btg_accum #(.W(BAUD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(run), .incr(baud_val), .carry(acc_carry)
  );

  assign tick_next = (mode == MODE_ACC) ? acc_carry : div_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= tick_next;
  end

  btg_prescale #(.RATIO(OSR)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_in(tick_next), .tick_out(bit_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] baud_val,
  input logic        frac_mode,
  input logic        run,
  input logic        os_tick,
  input logic        bit_tick
);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!os_tick && !bit_tick));

  p_bit_with_os_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  p_div_first_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run) && !frac_mode) |=> os_tick);

  p_acc_first_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run) && frac_mode) |=> !os_tick);

  p_acc_no_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && frac_mode && $past(frac_mode) && $stable(baud_val)
     && baud_val < 16'h8000 && os_tick) |=> !os_tick);

  p_div_small_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !frac_mode && !$past(frac_mode) && os_tick
     && baud_val <= 16'd1) |=> os_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_val(baud_val), .frac_mode(frac_mode),
  .run(run), .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_tb.sv
`timescale 1ns/1ps
module baud_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_val = '0;
  logic        frac_mode = 1'b0;
  logic        run = 1'b0;
  logic        os_tick;
  logic        bit_tick;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  os;
    logic  bt;
    string tag;
  } exp_t;
  exp_t sbq[$];

  // reference state, kept in the bench's own terms
  int wait_left = 0;   // divider: non-firing edges before the next tick
  int phase     = 0;   // accumulator phase
  int nticks    = 0;   // ticks since run rose

  always #5 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .baud_val(baud_val), .frac_mode(frac_mode),
    .run(run), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  // one cycle: drive inputs for the coming edge and push what follows it
  task automatic step(input bit r, input bit m, input int b, input string tag);
    exp_t e;
    bit df, af, f;
    @(negedge clk);
    run = r; frac_mode = m; baud_val = 16'(b);
    if (!r) begin
      wait_left = 0; phase = 0; nticks = 0; f = 0;
      e.bt = 0;
    end else begin
      df = (wait_left == 0);
      if (df) wait_left = (b < 2) ? 0 : b - 1;
      else    wait_left = wait_left - 1;
      phase = phase + b;
      af = (phase >= 65536);
      if (af) phase = phase - 65536;
      f = m ? af : df;
      e.bt = 0;
      if (f) begin
        nticks = nticks + 1;
        e.bt = ((nticks % 16) == 0);
      end
    end
    e.os = f;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic seg(input bit r, input bit m, input int b, input int n, input string tag);
    for (int i = 0; i < n; i++) step(r, m, b, tag);
  endtask

  // monitor: compare after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        tests++;
        if (os_tick !== e.os || bit_tick !== e.bt) begin
          fails++;
          $display("FAIL %s: os_tick/bit_tick actual %b%b expected %b%b at %0t",
                   e.tag, os_tick, bit_tick, e.os, e.bt, $time);
        end
      end
    end
  end

  initial begin
    #1;
    tests++;
    if (os_tick !== 1'b0 || bit_tick !== 1'b0) begin
      fails++;
      $display("FAIL R9: in reset actual %b%b expected 00", os_tick, bit_tick);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seg(0, 0, 5, 4, "R9");
    seg(1, 0, 5, 120, "R1/R7");          // divider, period 5
    seg(0, 0, 5, 6, "R5");
    seg(1, 0, 5, 40, "R5");              // restart repeats the timing
    seg(0, 0, 1, 3, "R5");
    seg(1, 0, 1, 40, "R2");              // count 1
    seg(0, 0, 0, 3, "R5");
    seg(1, 0, 0, 40, "R2");              // count 0
    seg(0, 0, 7, 3, "R5");
    seg(1, 0, 7, 10, "R6");
    seg(1, 0, 3, 60, "R6");              // rewrite mid interval
    seg(0, 1, 16'h3000, 3, "R5");
    seg(1, 1, 16'h3000, 200, "R3/R4");   // same pattern each run
    seg(0, 1, 16'h5555, 3, "R5");
    seg(1, 1, 16'h5555, 200, "R3/R7");
    seg(0, 1, 16'hC000, 3, "R5");
    seg(1, 1, 16'hC000, 100, "R3");      // back-to-back ticks
    seg(0, 1, 16'h0101, 3, "R5");
    seg(1, 1, 16'h0101, 400, "R3");
    seg(1, 1, 16'h9000, 50, "R8");       // rewrite while running
    seg(0, 0, 16'h3000, 3, "R5");
    seg(1, 0, 16'h3000, 30, "R4");       // same value, divider selected
    seg(0, 0, 0, 3, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule